// File: doc/BRIEF.md
# Serial NOR flash program and erase sequencer

This block turns a single program or erase request into the ordered series of commands that a serial NOR flash needs. A generic command port does the actual bus traffic. The block presents an opcode, an address, an address width and a byte count on that port, pulses a start strobe, and waits until the port drops its busy flag. Status bytes come back through a small receive interface. The block clears that interface after it has looked at each byte.

Page program data, up to one page, is loaded beforehand into an internal word buffer through an indexed write port. On a program request the block does three things in order. First it repeats write-enable plus a one-byte status read until the write-enable latch bit shows up in the status byte. Next it streams the needed data words to the command port. Last it launches the page-program command. An erase request sends write-enable once and then the sector-erase command, with no status polling.

The program and erase opcodes, and the address width, follow the flash size parameter. The block finishes each request with a one-cycle done pulse. If the latch never shows up within the configured number of polls, it sets an error flag and skips the program command.

Top module: `flash_pe_ctrl`

## Requirements
- R1: After reset, busy, done, err, cp_start, cp_rx_clear and cp_tx_valid are all 0.
- R2: A program request issues write-enable (opcode 0x06, 0 address bytes, length 0) followed by read-status (opcode 0x05, 0 address bytes, length 1). The pair repeats until the returned status byte has bit 1 (mask 0x02) set. A missing status byte (cp_rx_valid low) counts as not set.
- R3: cp_rx_clear pulses for exactly one cycle after every completed read-status command. It is never pulsed during an erase.
- R4: Once the latch is seen, ceil(L/4) buffer words (index 0 upward) are sent on cp_tx_word, one per cycle with cp_tx_valid high, before page-program starts. L is the request length clipped to PAGE_MAX (64).
- R5: Page program uses opcode 0x02 with 3 address bytes when FLASH_BYTES is at most 16 MiB, and opcode 0x12 with 4 address bytes otherwise. Its cp_len is L.
- R6: An erase request issues write-enable once and then sector erase: opcode 0xD8 with 3 address bytes, or 0xDC with 4. It issues no status read.
- R7: cp_start is never raised while cp_busy is high. The next command starts only after the port has reported not busy.
- R8: The program and erase address is ADDR_BASE plus the low 24 bits of the request offset.
- R9: done is high for exactly one cycle, starting in the cycle after the final command's busy ends. busy is low in the following cycle.
- R10: While busy, new requests and buffer word loads are ignored. No further command is issued, and the buffer contents are unchanged.
- R11: If MAX_POLL write-enable/status pairs pass without the latch bit, err rises together with done and no page program is issued.
- R12: err stays set until the next accepted request, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_erase | input | 1 | 1 = sector erase, 0 = page program |
| req_offset | input | 32 | Byte offset in the flash, low 24 bits used |
| req_len | input | REQ_LEN_W | Program length in bytes, clipped to PAGE_MAX |
| ld_we | input | 1 | Buffer word write strobe, taken only when idle |
| ld_idx | input | IDX_W | Buffer word index |
| ld_word | input | 32 | Buffer word data |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Latch polling gave up |
| cp_start | output | 1 | Command start strobe |
| cp_opcode | output | 8 | Command opcode |
| cp_addr | output | 32 | Command address |
| cp_addr_bytes | output | 3 | Address bytes to send (0, 3 or 4) |
| cp_len | output | LEN_W | Data bytes to read or write |
| cp_busy | input | 1 | Port busy, high from the cycle after cp_start until done |
| cp_rx_valid | input | 1 | A status byte is available |
| cp_rx_byte | input | 8 | Received status byte |
| cp_rx_clear | output | 1 | Discard the received byte |
| cp_tx_valid | output | 1 | cp_tx_word holds a data word |
| cp_tx_word | output | 32 | Program data word |

## Verification
The embedded assertions check the per-cycle properties on every cycle. A start never coincides with a busy port. Data words never go out while the port is busy. done is a single-cycle pulse, and err rises only together with done. The status-read path is never entered for an erase. The buffer holds still while a request runs.

Only the directed scenarios can show the sequence-level facts. These are the exact order of opcodes across several failed polls, the number of receive clears, the order and count of the data words relative to the program start, the clipping of long lengths, the address sum, the polling give-up count, and the clearing of err by the next request.

// File: rtl/pe_pkg.sv
package pe_pkg;

   localparam logic [7:0] OPC_WREN = 8'h06;
   localparam logic [7:0] OPC_RDST = 8'h05;
   localparam logic [7:0] OPC_PP3  = 8'h02;
   localparam logic [7:0] OPC_PP4  = 8'h12;
   localparam logic [7:0] OPC_SE3  = 8'hD8;
   localparam logic [7:0] OPC_SE4  = 8'hDC;
   localparam logic [7:0] WEL_MASK = 8'h02;

   typedef enum logic {
      OP_PROGRAM = 1'b0,
      OP_ERASE   = 1'b1
   } pe_kind_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_WREN_GO,
      ST_WREN_WT,
      ST_RDST_GO,
      ST_RDST_WT,
      ST_STAT,
      ST_PUSH,
      ST_PP_GO,
      ST_PP_WT,
      ST_SE_GO,
      ST_SE_WT,
      ST_FIN
   } pe_state_e;

endpackage

// File: rtl/pe_word_buf.sv
module pe_word_buf #(
   parameter int WORDS = 16,
   parameter int WORD_W = 32,
   localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_we_i,
   input  logic [IDX_W-1:0]  ld_idx_i,
   input  logic [WORD_W-1:0] ld_word_i,
   input  logic              lock_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   output logic [WORD_W-1:0] rd_word_o
);

   generate
      if (WORDS < 1) begin : g_bad_words
         $error("pe_word_buf: WORDS must be at least 1");
      end
   endgenerate

   logic [WORDS-1:0][WORD_W-1:0] mem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_q <= '0;
      end else if (ld_we_i && !lock_i && (int'(ld_idx_i) < WORDS)) begin
         mem_q[ld_idx_i] <= ld_word_i;
      end
   end

   always_comb begin
      rd_word_o = '0;
      if (int'(rd_idx_i) < WORDS) rd_word_o = mem_q[rd_idx_i];
   end

   // R10
   buf_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_i |=> $stable(mem_q));

endmodule

// File: rtl/pe_cmd_fmt.sv
module pe_cmd_fmt
   import pe_pkg::*;
#(
   parameter longint unsigned FLASH_BYTES = 64'd16777216,
   parameter logic [31:0]     ADDR_BASE   = 32'h6000_0000,
   parameter int              LEN_W       = 7
) (
   input  pe_state_e         state_i,
   input  logic [31:0]       off_i,
   input  logic [LEN_W-1:0]  len_i,
   output logic [7:0]        opcode_o,
   output logic [31:0]       addr_o,
   output logic [2:0]        abytes_o,
   output logic [LEN_W-1:0]  len_o
);

   localparam longint unsigned SMALL_LIMIT = 64'd16777216;
   localparam bit WIDE = (FLASH_BYTES > SMALL_LIMIT);

   logic [7:0] pp_op;
   logic [7:0] se_op;
   logic [2:0] ab;

   generate
      if (WIDE) begin : g_wide_addr
         assign pp_op = OPC_PP4;
         assign se_op = OPC_SE4;
         assign ab    = 3'd4;
      end else begin : g_narrow_addr
         assign pp_op = OPC_PP3;
         assign se_op = OPC_SE3;
         assign ab    = 3'd3;
      end
   endgenerate

   assign addr_o = ADDR_BASE + (off_i & 32'h00FF_FFFF);

   always_comb begin
      opcode_o = 8'h00;
      abytes_o = 3'd0;
      len_o    = '0;
      unique case (state_i)
         ST_WREN_GO, ST_WREN_WT: begin
            opcode_o = OPC_WREN;
         end
         ST_RDST_GO, ST_RDST_WT: begin
            opcode_o = OPC_RDST;
            len_o    = LEN_W'(1);
         end
         ST_PP_GO, ST_PP_WT: begin
            opcode_o = pp_op;
            abytes_o = ab;
            len_o    = len_i;
         end
         ST_SE_GO, ST_SE_WT: begin
            opcode_o = se_op;
            abytes_o = ab;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/pe_seq.sv
module pe_seq
   import pe_pkg::*;
#(
   parameter int MAX_POLL  = 16,
   parameter int PAGE_MAX  = 64,
   parameter int REQ_LEN_W = 8,
   localparam int LEN_W  = $clog2(PAGE_MAX + 1),
   localparam int WORDS  = (PAGE_MAX + 3) / 4,
   localparam int IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1,
   localparam int CNT_W  = IDX_W + 1,
   localparam int POLL_W = $clog2(MAX_POLL + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid_i,
   input  logic                 req_erase_i,
   input  logic [31:0]          req_offset_i,
   input  logic [REQ_LEN_W-1:0] req_len_i,
   input  logic                 cp_busy_i,
   input  logic                 cp_rx_valid_i,
   input  logic [7:0]           cp_rx_byte_i,
   output pe_state_e            state_o,
   output logic [31:0]          off_o,
   output logic [LEN_W-1:0]     len_o,
   output logic [IDX_W-1:0]     rd_idx_o,
   output logic                 busy_o,
   output logic                 done_o,
   output logic                 err_o,
   output logic                 cp_start_o,
   output logic                 cp_rx_clear_o,
   output logic                 cp_tx_valid_o
);

   generate
      if (MAX_POLL < 1) begin : g_bad_poll
         $error("pe_seq: MAX_POLL must be at least 1");
      end
      if ((2 ** REQ_LEN_W) <= PAGE_MAX) begin : g_bad_len
         $error("pe_seq: REQ_LEN_W too narrow for PAGE_MAX");
      end
   endgenerate

   pe_state_e          state_q;
   pe_kind_e           kind_q;
   logic [31:0]        off_q;
   logic [LEN_W-1:0]   len_q;
   logic [POLL_W-1:0]  poll_q;
   logic [CNT_W-1:0]   push_q;
   logic               err_q;

   logic [LEN_W-1:0]   len_clip;
   logic [LEN_W:0]     len_plus;
   logic [LEN_W-1:0]   nwords;
   logic               wel_seen;
   logic               last_push;

   always_comb begin
      if (int'(req_len_i) > PAGE_MAX) len_clip = LEN_W'(PAGE_MAX);
      else                            len_clip = LEN_W'(req_len_i);
   end

   assign len_plus  = {1'b0, len_q} + (LEN_W + 1)'(3);
   assign nwords    = LEN_W'(len_plus >> 2);
   assign wel_seen  = cp_rx_valid_i && ((cp_rx_byte_i & WEL_MASK) != 8'h00);
   assign last_push = ((LEN_W'(push_q) + LEN_W'(1)) == nwords);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         kind_q  <= OP_PROGRAM;
         off_q   <= '0;
         len_q   <= '0;
         poll_q  <= '0;
         push_q  <= '0;
         err_q   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid_i) begin
                  kind_q  <= req_erase_i ? OP_ERASE : OP_PROGRAM;
                  off_q   <= req_offset_i;
                  len_q   <= len_clip;
                  poll_q  <= '0;
                  push_q  <= '0;
                  err_q   <= 1'b0;
                  state_q <= ST_WREN_GO;
               end
            end
            ST_WREN_GO: state_q <= ST_WREN_WT;
            ST_WREN_WT: begin
               if (!cp_busy_i) state_q <= (kind_q == OP_ERASE) ? ST_SE_GO : ST_RDST_GO;
            end
            ST_RDST_GO: state_q <= ST_RDST_WT;
            ST_RDST_WT: begin
               if (!cp_busy_i) state_q <= ST_STAT;
            end
            ST_STAT: begin
               if (wel_seen) begin
                  state_q <= (nwords == '0) ? ST_PP_GO : ST_PUSH;
               end else if (poll_q == POLL_W'(MAX_POLL - 1)) begin
                  err_q   <= 1'b1;
                  state_q <= ST_FIN;
               end else begin
                  poll_q  <= poll_q + POLL_W'(1);
                  state_q <= ST_WREN_GO;
               end
            end
            ST_PUSH: begin
               push_q <= push_q + CNT_W'(1);
               if (last_push) state_q <= ST_PP_GO;
            end
            ST_PP_GO: state_q <= ST_PP_WT;
            ST_PP_WT: begin
               if (!cp_busy_i) state_q <= ST_FIN;
            end
            ST_SE_GO: state_q <= ST_SE_WT;
            ST_SE_WT: begin
               if (!cp_busy_i) state_q <= ST_FIN;
            end
            ST_FIN:  state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign state_o       = state_q;
   assign off_o         = off_q;
   assign len_o         = len_q;
   assign rd_idx_o      = push_q[IDX_W-1:0];
   assign busy_o        = (state_q != ST_IDLE);
   assign done_o        = (state_q == ST_FIN);
   assign err_o         = err_q;
   assign cp_start_o    = (state_q == ST_WREN_GO) || (state_q == ST_RDST_GO) ||
                          (state_q == ST_PP_GO)   || (state_q == ST_SE_GO);
   assign cp_rx_clear_o = (state_q == ST_STAT);
   assign cp_tx_valid_o = (state_q == ST_PUSH);

   // R7
   start_idle_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cp_start_o |-> !cp_busy_i);

   // R4
   push_idle_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cp_tx_valid_o |-> !cp_busy_i);

   // R9
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R11
   err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> done_o);

   // R6
   erase_no_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RDST_GO) |-> (kind_q == OP_PROGRAM));

endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
   import pe_pkg::*;
#(
   parameter longint unsigned FLASH_BYTES = 64'd16777216,
   parameter logic [31:0]     ADDR_BASE   = 32'h6000_0000,
   parameter int              PAGE_MAX    = 64,
   parameter int              MAX_POLL    = 16,
   parameter int              REQ_LEN_W   = 8,
   localparam int LEN_W = $clog2(PAGE_MAX + 1),
   localparam int WORDS = (PAGE_MAX + 3) / 4,
   localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic                 req_erase,
   input  logic [31:0]          req_offset,
   input  logic [REQ_LEN_W-1:0] req_len,
   input  logic                 ld_we,
   input  logic [IDX_W-1:0]     ld_idx,
   input  logic [31:0]          ld_word,
   output logic                 busy,
   output logic                 done,
   output logic                 err,
   output logic                 cp_start,
   output logic [7:0]           cp_opcode,
   output logic [31:0]          cp_addr,
   output logic [2:0]           cp_addr_bytes,
   output logic [LEN_W-1:0]     cp_len,
   input  logic                 cp_busy,
   input  logic                 cp_rx_valid,
   input  logic [7:0]           cp_rx_byte,
   output logic                 cp_rx_clear,
   output logic                 cp_tx_valid,
   output logic [31:0]          cp_tx_word
);

   generate
      if (PAGE_MAX < 1) begin : g_bad_page
         $error("flash_pe_ctrl: PAGE_MAX must be at least 1");
      end
   endgenerate

   pe_state_e         st;
   logic [31:0]       off_q;
   logic [LEN_W-1:0]  len_q;
   logic [IDX_W-1:0]  rd_idx;
   logic              busy_int;

   pe_seq #(
      .MAX_POLL  (MAX_POLL),
      .PAGE_MAX  (PAGE_MAX),
      .REQ_LEN_W (REQ_LEN_W)
   ) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid_i   (req_valid),
      .req_erase_i   (req_erase),
      .req_offset_i  (req_offset),
      .req_len_i     (req_len),
      .cp_busy_i     (cp_busy),
      .cp_rx_valid_i (cp_rx_valid),
      .cp_rx_byte_i  (cp_rx_byte),
      .state_o       (st),
      .off_o         (off_q),
      .len_o         (len_q),
      .rd_idx_o      (rd_idx),
      .busy_o        (busy_int),
      .done_o        (done),
      .err_o         (err),
      .cp_start_o    (cp_start),
      .cp_rx_clear_o (cp_rx_clear),
      .cp_tx_valid_o (cp_tx_valid)
   );

   pe_cmd_fmt #(
      .FLASH_BYTES (FLASH_BYTES),
      .ADDR_BASE   (ADDR_BASE),
      .LEN_W       (LEN_W)
   ) u_fmt (
      .state_i  (st),
      .off_i    (off_q),
      .len_i    (len_q),
      .opcode_o (cp_opcode),
      .addr_o   (cp_addr),
      .abytes_o (cp_addr_bytes),
      .len_o    (cp_len)
   );

   pe_word_buf #(
      .WORDS  (WORDS),
      .WORD_W (32)
   ) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_we_i   (ld_we),
      .ld_idx_i  (ld_idx),
      .ld_word_i (ld_word),
      .lock_i    (busy_int),
      .rd_idx_i  (rd_idx),
      .rd_word_o (cp_tx_word)
   );

   assign busy = busy_int;

endmodule

// File: tb/sim_flash_pe_ctrl.sv
module sim_flash_pe_ctrl;

   localparam int POLL  = 4;
   localparam int IDX_W = 4;
   localparam int LEN_W = 7;

   logic              clk;
   logic              rst_n;
   logic              req_valid;
   logic              req_erase;
   logic [31:0]       req_offset;
   logic [7:0]        req_len;
   logic              ld_we;
   logic [IDX_W-1:0]  ld_idx;
   logic [31:0]       ld_word;
   logic              busy;
   logic              done;
   logic              err;
   logic              cp_start;
   logic [7:0]        cp_opcode;
   logic [31:0]       cp_addr;
   logic [2:0]        cp_addr_bytes;
   logic [LEN_W-1:0]  cp_len;
   logic              cp_busy;
   logic              cp_rx_valid;
   logic [7:0]        cp_rx_byte;
   logic              cp_rx_clear;
   logic              cp_tx_valid;
   logic [31:0]       cp_tx_word;

   flash_pe_ctrl #(.MAX_POLL(POLL)) u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_erase(req_erase),
      .req_offset(req_offset), .req_len(req_len),
      .ld_we(ld_we), .ld_idx(ld_idx), .ld_word(ld_word),
      .busy(busy), .done(done), .err(err),
      .cp_start(cp_start), .cp_opcode(cp_opcode), .cp_addr(cp_addr),
      .cp_addr_bytes(cp_addr_bytes), .cp_len(cp_len),
      .cp_busy(cp_busy), .cp_rx_valid(cp_rx_valid), .cp_rx_byte(cp_rx_byte),
      .cp_rx_clear(cp_rx_clear), .cp_tx_valid(cp_tx_valid), .cp_tx_word(cp_tx_word)
   );

   initial clk = 1'b0;
   always #2 clk = ~clk;

   int total = 0;
   int bad   = 0;

   // command port model and logs
   logic [7:0]  op_log   [0:63];
   logic [31:0] addr_log [0:63];
   int          len_log  [0:63];
   int          ab_log   [0:63];
   logic [31:0] tx_log   [0:31];
   int n_cmd, n_tx, tx_at_pp, n_clr, viol, nr_left, bcnt;
   logic [7:0] cur_op;
   bit never_rdy;

   function automatic logic [31:0] wpat(int i);
      return 32'hC0DE_0000 | (i * 32'h0000_0111);
   endfunction

   task automatic chk(bit ok, string req, longint act, longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   initial begin
      cp_busy = 1'b0; cp_rx_valid = 1'b0; cp_rx_byte = 8'h00;
      n_cmd = 0; n_tx = 0; tx_at_pp = -1; n_clr = 0; viol = 0;
      nr_left = 0; never_rdy = 1'b0; bcnt = 0; cur_op = 8'h00;
      forever begin
         @(posedge clk);
         if (cp_start) begin
            if (cp_busy) viol++;
            if (n_cmd < 64) begin
               op_log[n_cmd]   = cp_opcode;
               addr_log[n_cmd] = cp_addr;
               len_log[n_cmd]  = int'(cp_len);
               ab_log[n_cmd]   = int'(cp_addr_bytes);
            end
            n_cmd++;
            if (cp_opcode == 8'h02 || cp_opcode == 8'h12) tx_at_pp = n_tx;
            cur_op = cp_opcode;
            cp_busy <= 1'b1;
            bcnt = 3;
         end else if (cp_busy) begin
            bcnt--;
            if (bcnt == 0) begin
               cp_busy <= 1'b0;
               if (cur_op == 8'h05) begin
                  cp_rx_valid <= 1'b1;
                  if (never_rdy || nr_left > 0) begin
                     cp_rx_byte <= 8'hFD;
                     if (nr_left > 0) nr_left--;
                  end else begin
                     cp_rx_byte <= 8'h02;
                  end
               end
            end
         end
         if (cp_tx_valid) begin
            if (n_tx < 32) tx_log[n_tx] = cp_tx_word;
            n_tx++;
         end
         if (cp_rx_clear) begin
            n_clr++;
            cp_rx_valid <= 1'b0;
         end
      end
   end

   task automatic clear_logs();
      n_cmd = 0; n_tx = 0; tx_at_pp = -1; n_clr = 0;
   endtask

   task automatic issue(bit erase, logic [31:0] off, int len);
      @(negedge clk);
      req_valid = 1'b1; req_erase = erase; req_offset = off; req_len = 8'(len);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // returns at the negedge where done is seen high
   task automatic wait_done();
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (done) return;
      end
      chk(1'b0, "R9 done never seen", 0, 1);
   endtask

   task automatic after_done(string tag);
      chk(done == 1'b1, {tag, " R9 done high"}, done, 1);
      @(negedge clk);
      chk(done == 1'b0, {tag, " R9 done one cycle"}, done, 0);
      chk(busy == 1'b0, {tag, " R9 idle after done"}, busy, 0);
   endtask

   task automatic load_all();
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         ld_we = 1'b1; ld_idx = IDX_W'(i); ld_word = wpat(i);
      end
      @(negedge clk);
      ld_we = 1'b0;
   endtask

   task automatic t_reset();
      // R1
      chk(busy == 1'b0 && done == 1'b0 && err == 1'b0, "R1 status idle",
          {busy, done, err}, 0);
      chk(cp_start == 1'b0 && cp_rx_clear == 1'b0 && cp_tx_valid == 1'b0,
          "R1 port strobes idle", {cp_start, cp_rx_clear, cp_tx_valid}, 0);
   endtask

   task automatic t_program_polls();
      logic [7:0] exp_ops [0:6];
      exp_ops = '{8'h06, 8'h05, 8'h06, 8'h05, 8'h06, 8'h05, 8'h02};
      clear_logs(); nr_left = 2;
      issue(1'b0, 32'h12AB_CDEF, 10);
      wait_done();
      chk(n_cmd == 7, "R2 command count with two failed polls", n_cmd, 7);
      for (int i = 0; i < 7; i++)
         chk(op_log[i] == exp_ops[i], "R2 opcode order", op_log[i], exp_ops[i]);
      chk(ab_log[0] == 0 && len_log[0] == 0, "R2 write-enable form", len_log[0], 0);
      chk(ab_log[1] == 0 && len_log[1] == 1, "R2 status read length", len_log[1], 1);
      chk(n_clr == 3, "R3 one clear per status read", n_clr, 3);
      chk(n_tx == 3 && tx_at_pp == 3, "R4 three words before program", tx_at_pp, 3);
      for (int i = 0; i < 3; i++)
         chk(tx_log[i] == wpat(i), "R4 word order", tx_log[i], wpat(i));
      chk(ab_log[6] == 3 && len_log[6] == 10, "R5 program form", len_log[6], 10);
      chk(addr_log[6] == 32'h60AB_CDEF, "R8 program address", addr_log[6], 32'h60AB_CDEF);
      chk(viol == 0, "R7 start while busy", viol, 0);
      chk(err == 1'b0, "R11 no error when latch seen", err, 0);
      after_done("program");
   endtask

   task automatic t_clip();
      clear_logs(); nr_left = 0;
      issue(1'b0, 32'h0000_0100, 200);
      wait_done();
      chk(n_cmd == 3 && op_log[2] == 8'h02, "R5 program issued", op_log[2], 8'h02);
      chk(len_log[2] == 64, "R4 length clipped to 64", len_log[2], 64);
      chk(n_tx == 16 && tx_at_pp == 16, "R4 sixteen words", n_tx, 16);
      chk(tx_log[15] == wpat(15), "R4 last word", tx_log[15], wpat(15));
      after_done("clip");
   endtask

   task automatic t_erase_ignore();
      clear_logs();
      issue(1'b1, 32'hFF34_5678, 0);
      repeat (3) @(negedge clk);
      // R10: request and load during busy
      req_valid = 1'b1; req_erase = 1'b0; req_offset = 32'h0; req_len = 8'd8;
      ld_we = 1'b1; ld_idx = '0; ld_word = 32'hDEAD_BEEF;
      @(negedge clk);
      req_valid = 1'b0; ld_we = 1'b0;
      wait_done();
      chk(n_cmd == 2, "R6 two erase commands", n_cmd, 2);
      chk(op_log[0] == 8'h06 && op_log[1] == 8'hD8, "R6 erase opcodes", op_log[1], 8'hD8);
      chk(ab_log[1] == 3, "R6 erase address bytes", ab_log[1], 3);
      chk(addr_log[1] == 32'h6034_5678, "R8 erase address", addr_log[1], 32'h6034_5678);
      chk(n_clr == 0, "R3 no clear during erase", n_clr, 0);
      after_done("erase");
      repeat (6) @(negedge clk);
      chk(n_cmd == 2 && busy == 1'b0, "R10 ignored request started nothing", n_cmd, 2);
      clear_logs(); nr_left = 0;
      issue(1'b0, 32'h0, 4);
      wait_done();
      chk(n_tx == 1 && tx_log[0] == wpat(0), "R10 buffer unchanged by busy load",
          tx_log[0], wpat(0));
      after_done("recheck");
   endtask

   task automatic t_poll_limit();
      clear_logs(); never_rdy = 1'b1;
      issue(1'b0, 32'h40, 8);
      wait_done();
      chk(err == 1'b1, "R11 err with done", err, 1);
      chk(n_cmd == 2 * POLL, "R11 pair count", n_cmd, 2 * POLL);
      chk(op_log[2 * POLL - 1] == 8'h05, "R11 last command is status read",
          op_log[2 * POLL - 1], 8'h05);
      chk(n_tx == 0 && tx_at_pp == -1, "R11 no program issued", n_tx, 0);
      chk(n_clr == POLL, "R3 clears during failed polls", n_clr, POLL);
      after_done("limit");
      chk(err == 1'b1, "R12 err held while idle", err, 1);
      never_rdy = 1'b0; nr_left = 0; clear_logs();
      issue(1'b0, 32'h40, 1);
      chk(err == 1'b0, "R12 err cleared by new request", err, 0);
      wait_done();
      chk(n_tx == 1 && op_log[2] == 8'h02, "R12 program after recovery", op_log[2], 8'h02);
      after_done("recover");
   endtask

   initial begin
      #400_000;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_erase = 1'b0; req_offset = '0;
      req_len = '0; ld_we = 1'b0; ld_idx = '0; ld_word = '0;
      repeat (5) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      load_all();
      t_program_polls();
      t_clip();
      t_erase_ignore();
      t_poll_limit();
      chk(viol == 0, "R7 no start while port busy", viol, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule